// File: doc/BRIEF.md
# Presence-Bit Direct Token Matcher

This block pairs operand tokens for a dataflow processing element. Each token carries a frame pointer, an instruction pointer, a data value and a flag that says whether it feeds the left or the right operand. The instruction pointer is decoded into a frame offset, an operation and one or two destinations. The frame pointer plus that offset addresses one rendezvous slot in a small frame store. There is no search over tags.

A slot holds one value and a presence bit. The first token to reach an empty slot leaves its value there and sets the bit. The second token to reach that slot takes the value out and clears the bit. The two operands are then ordered left and right, combined by the ALU, and sent out as one or two result tokens. Each result token keeps the frame pointer and adds a fixed displacement to the instruction pointer.

Both streams use valid/ready. An input token is taken on a clock edge where `in_valid` and `in_ready` are both high. An output token leaves on an edge where `out_valid` and `out_ready` are both high. While output tokens are still waiting, `in_ready` is low, except in the cycle that the last of them leaves. A held output does not change until it is taken.

Top module: `token_matcher`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and every presence bit is clear. A reset in the middle of a run also clears a parked operand, so the next token to that slot parks.
- R2: The slot index is (`in_fp` + offset) modulo 2^FP_W, where the offset is `in_ip[2:0]`. Two tokens with different frame pointers but the same index meet in the same slot.
- R3: A token that finds its slot empty writes its value, sets the presence bit and produces no output token.
- R4: A token that finds its slot full fires. The slot becomes empty again, so a third token to that slot parks. The first result token is valid in the cycle after the accepting edge.
- R5: On a firing, the arriving value is the right operand when `in_port`=1 and the left operand when `in_port`=0. The parked value takes the other side.
- R6: The opcode `in_ip[4:3]` selects the result: 0 gives left+right, 1 gives left−right, 2 gives left AND right, 3 gives left XOR right. All results wrap at DATA_W bits.
- R7: The first result token has `out_fp` equal to the firing token's frame pointer, `out_ip` equal to its instruction pointer +1 (mod 2^7) and `out_port` equal to `in_ip[6]`.
- R8: When `in_ip[5]`=1, a second result token follows on the next handshake cycle. It has `out_ip` equal to the instruction pointer +2 and `out_port` equal to the inverse of `in_ip[6]`. `in_ready` stays low until the last token leaves.
- R9: While `out_valid` is 1 and `out_ready` is 0, every output field holds steady and `in_ready` is 0.
- R10: Two tokens for the same slot, accepted on consecutive edges, pair correctly: the second one sees the presence bit set by the first.
- R11: Tokens whose slot indexes differ do not disturb each other's parked operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An input token is offered |
| in_ready | output | 1 | The block takes the offered token on this edge |
| in_fp | input | FP_W | Frame pointer of the input token |
| in_ip | input | OFF_W+4 | Instruction pointer of the input token |
| in_port | input | 1 | 0 = left operand, 1 = right operand |
| in_data | input | DATA_W | Operand value |
| out_valid | output | 1 | A result token is offered |
| out_ready | input | 1 | The consumer takes the result token on this edge |
| out_fp | output | FP_W | Frame pointer of the result token |
| out_ip | output | OFF_W+4 | Instruction pointer of the destination |
| out_port | output | 1 | Operand side at the destination |
| out_data | output | DATA_W | Result value |

## Verification
The assertions assume that the consumer may hold `out_ready` low for any number of cycles, and that inputs change only between clock edges. The result-token checks also assume that a rising `out_valid` can only follow an input accepted on the edge before. The bench drives every input on the falling edge and holds `in_valid` until it sees `in_ready`. It stalls the consumer only in the directed back-pressure test, and it resets only between whole tokens.

// File: rtl/tm_pkg.sv
package tm_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } op_e;

  typedef struct packed {
    logic [1:0] disp;
    logic       port;
  } dest_t;

  localparam logic [1:0] DISP_FIRST  = 2'd1;
  localparam logic [1:0] DISP_SECOND = 2'd2;
endpackage

// File: rtl/tm_instr_rom.sv
module tm_instr_rom import tm_pkg::*; #(
  parameter int OFF_W = 3,
  localparam int IP_W = OFF_W + 4
) (
  input  logic [IP_W-1:0]  ip,
  output op_e              op,
  output logic [OFF_W-1:0] off,
  output logic             two,
  output dest_t            d0,
  output dest_t            d1
);
  // Word fields: [OFF_W-1:0] offset, next two bits opcode,
  // then two-destination flag, then port of the first destination.
  assign off     = ip[OFF_W-1:0];
  assign op      = op_e'(ip[OFF_W+1:OFF_W]);
  assign two     = ip[OFF_W+2];
  assign d0.disp = DISP_FIRST;
  assign d0.port = ip[OFF_W+3];
  assign d1.disp = DISP_SECOND;
  assign d1.port = ~ip[OFF_W+3];
endmodule

// File: rtl/tm_frame_store.sv
module tm_frame_store #(
  parameter int SLOT_W = 4,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] addr,
  output logic              rd_full,
  output logic [DATA_W-1:0] rd_val,
  input  logic              park_en,
  input  logic [DATA_W-1:0] park_val,
  input  logic              take_en
);
  logic [DEPTH-1:0]  full_q;
  logic [DATA_W-1:0] val_q [DEPTH];

  // Reads are combinational and writes land on the same edge, so the next
  // token always sees the updated presence state.
  assign rd_full = full_q[addr];
  assign rd_val  = val_q[addr];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        full_q[s] <= 1'b0;
      else if (addr == SLOT_W'(s)) begin
        if (park_en)      full_q[s] <= 1'b1;
        else if (take_en) full_q[s] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (park_en && addr == SLOT_W'(s))
        val_q[s] <= park_val;
    end
  end
endmodule

// File: rtl/tm_alu.sv
module tm_alu import tm_pkg::*; #(
  parameter int DATA_W = 16
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      default: y = a ^ b;
    endcase
  end
endmodule

// File: rtl/tm_result_former.sv
module tm_result_former import tm_pkg::*; #(
  parameter int FP_W   = 4,
  parameter int IP_W   = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [FP_W-1:0]   ld_fp,
  input  logic [IP_W-1:0]   ld_ip,
  input  logic [DATA_W-1:0] ld_val,
  input  logic              ld_two,
  input  dest_t             ld_d0,
  input  dest_t             ld_d1,
  output logic              can_take,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FP_W-1:0]   out_fp,
  output logic [IP_W-1:0]   out_ip,
  output logic              out_port,
  output logic [DATA_W-1:0] out_data
);
  logic [1:0]        pend_q;
  logic              sel1_q;
  logic [FP_W-1:0]   fp_q;
  logic [IP_W-1:0]   ip_q;
  logic [DATA_W-1:0] val_q;
  dest_t             d0_q, d1_q;
  dest_t             cur;
  logic              hs;

  assign hs        = out_valid && out_ready;
  assign out_valid = (pend_q != 2'd0);
  assign can_take  = (pend_q == 2'd0) || (pend_q == 2'd1 && out_ready);
  assign cur       = sel1_q ? d1_q : d0_q;
  assign out_fp    = fp_q;
  assign out_ip    = ip_q + IP_W'(cur.disp);
  assign out_port  = cur.port;
  assign out_data  = val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 2'd0;
      sel1_q <= 1'b0;
    end else if (load) begin
      pend_q <= ld_two ? 2'd2 : 2'd1;
      sel1_q <= 1'b0;
    end else if (hs) begin
      pend_q <= pend_q - 2'd1;
      sel1_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      fp_q  <= ld_fp;
      ip_q  <= ld_ip;
      val_q <= ld_val;
      d0_q  <= ld_d0;
      d1_q  <= ld_d1;
    end
  end
endmodule

// File: rtl/token_matcher.sv
module token_matcher import tm_pkg::*; #(
  parameter int FP_W   = 4,
  parameter int OFF_W  = 3,
  parameter int DATA_W = 16,
  localparam int IP_W  = OFF_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FP_W-1:0]   in_fp,
  input  logic [IP_W-1:0]   in_ip,
  input  logic              in_port,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FP_W-1:0]   out_fp,
  output logic [IP_W-1:0]   out_ip,
  output logic              out_port,
  output logic [DATA_W-1:0] out_data
);
  op_e               op;
  logic [OFF_W-1:0]  off;
  logic              two;
  dest_t             d0, d1;
  logic [FP_W-1:0]   slot;
  logic              full;
  logic [DATA_W-1:0] parked;
  logic              acc, park_en, take_en;
  logic [DATA_W-1:0] opl, opr, res;

  tm_instr_rom #(.OFF_W(OFF_W)) u_rom (
    .ip(in_ip), .op(op), .off(off), .two(two), .d0(d0), .d1(d1)
  );

  assign slot    = in_fp + FP_W'(off);
  assign acc     = in_valid && in_ready;
  assign park_en = acc && !full;
  assign take_en = acc && full;

  tm_frame_store #(.SLOT_W(FP_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .addr(slot), .rd_full(full), .rd_val(parked),
    .park_en(park_en), .park_val(in_data), .take_en(take_en)
  );

  assign opl = in_port ? parked : in_data;
  assign opr = in_port ? in_data : parked;

  tm_alu #(.DATA_W(DATA_W)) u_alu (.op(op), .a(opl), .b(opr), .y(res));

  tm_result_former #(.FP_W(FP_W), .IP_W(IP_W), .DATA_W(DATA_W)) u_form (
    .clk(clk), .rst_n(rst_n), .load(take_en), .ld_fp(in_fp), .ld_ip(in_ip),
    .ld_val(res), .ld_two(two), .ld_d0(d0), .ld_d1(d1), .can_take(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_fp(out_fp),
    .out_ip(out_ip), .out_port(out_port), .out_data(out_data)
  );
endmodule

// File: rtl/tm_checker.sv
module tm_checker #(
  parameter int FP_W   = 4,
  parameter int IP_W   = 7,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [FP_W-1:0]   in_fp,
  input logic [IP_W-1:0]   in_ip,
  input logic              out_valid,
  input logic              out_ready,
  input logic [FP_W-1:0]   out_fp,
  input logic [IP_W-1:0]   out_ip,
  input logic              out_port,
  input logic [DATA_W-1:0] out_data
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !out_valid); // R1

  AST_FIRE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready)); // R4

  AST_FIRST_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_fp == $past(in_fp)) &&
                         (out_ip == IP_W'($past(in_ip) + 1'b1))); // R7

  AST_STALL_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R8

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_ip)
                                && $stable(out_fp) && $stable(out_port)); // R9
endmodule

bind token_matcher tm_checker #(.FP_W(FP_W), .IP_W(IP_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_fp(in_fp), .in_ip(in_ip), .out_valid(out_valid), .out_ready(out_ready),
  .out_fp(out_fp), .out_ip(out_ip), .out_port(out_port), .out_data(out_data)
);

// File: tb/tb_token_matcher.sv
module tb_token_matcher;
  localparam int FP_W = 4, OFF_W = 3, DATA_W = 16, IP_W = OFF_W + 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_port = 1'b0, out_ready = 1'b1;
  logic [FP_W-1:0] in_fp = '0;
  logic [IP_W-1:0] in_ip = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic in_ready, out_valid, out_port;
  logic [FP_W-1:0] out_fp;
  logic [IP_W-1:0] out_ip;
  logic [DATA_W-1:0] out_data;
  int nchk = 0, nerr = 0;

  token_matcher #(.FP_W(FP_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) dut (.*);

  always #10 clk = ~clk;

  typedef struct packed {
    logic [3:0]  fp;
    logic [6:0]  ip;
    logic        port;
    logic [15:0] data;
    logic [1:0]  n;
    logic [15:0] res;
  } vec_t;

  // ip fields: [2:0] offset, [4:3] opcode, [5] two dests, [6] first port
  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{4'h0, 7'h00, 1'b0, 16'd5,    2'd0, 16'h0000},
    '{4'h0, 7'h00, 1'b1, 16'd7,    2'd1, 16'd12},
    '{4'h2, 7'h09, 1'b1, 16'd3,    2'd0, 16'h0000},
    '{4'h2, 7'h09, 1'b0, 16'd10,   2'd1, 16'd7},
    '{4'h1, 7'h0A, 1'b0, 16'd4,    2'd0, 16'h0000},
    '{4'h1, 7'h0A, 1'b1, 16'd9,    2'd1, 16'hFFFB},
    '{4'h4, 7'h33, 1'b0, 16'h00FF, 2'd0, 16'h0000},
    '{4'h4, 7'h33, 1'b1, 16'h0F0F, 2'd2, 16'h000F},
    '{4'hE, 7'h7C, 1'b1, 16'hAAAA, 2'd0, 16'h0000},
    '{4'hE, 7'h7C, 1'b0, 16'h5555, 2'd2, 16'hFFFF},
    '{4'h5, 7'h01, 1'b0, 16'd1,    2'd0, 16'h0000},
    '{4'h6, 7'h01, 1'b0, 16'd2,    2'd0, 16'h0000},
    '{4'h5, 7'h01, 1'b1, 16'd10,   2'd1, 16'd11},
    '{4'h6, 7'h01, 1'b1, 16'd20,   2'd1, 16'd22},
    '{4'h3, 7'h02, 1'b0, 16'd100,  2'd0, 16'h0000},
    '{4'h5, 7'h00, 1'b1, 16'd1,    2'd1, 16'd101},
    '{4'h0, 7'h7F, 1'b0, 16'h1234, 2'd0, 16'h0000},
    '{4'h0, 7'h7F, 1'b1, 16'h1200, 2'd2, 16'h0034}
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [3:0] fp, logic [6:0] ip, logic port, logic [15:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_fp = fp; in_ip = ip; in_port = port; in_data = d;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Called on the falling edge after the accepting edge, out_ready high.
  task automatic expect_out(string req, int n, logic [3:0] fp, logic [6:0] ip,
                            logic [15:0] res);
    for (int k = 0; k < n; k++) begin
      logic [6:0] eip;
      eip = ip + 7'(k + 1);
      check(req, {out_valid, out_fp, out_ip, out_port, out_data},
                 {1'b1, fp, eip, ip[6] ^ k[0], res});
      @(negedge clk);
    end
    check({req, " idle"}, 64'(out_valid), 64'(0));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset out_valid", 64'(out_valid), 64'(0));
    check("R1 reset in_ready", 64'(in_ready), 64'(1));

    // Table: R2 R3 R4 R5 R6 R7 R8 R11
    for (int i = 0; i < NV; i++) begin
      send(VECS[i].fp, VECS[i].ip, VECS[i].port, VECS[i].data);
      expect_out(VECS[i].n == 0 ? "R3 park" : "R6 fire", int'(VECS[i].n),
                 VECS[i].fp, VECS[i].ip, VECS[i].res);
    end

    // R10: same slot, accepted on consecutive edges
    @(negedge clk);
    in_valid = 1'b1; in_fp = 4'h0; in_ip = 7'h00; in_port = 1'b0; in_data = 16'd20;
    @(negedge clk);
    in_port = 1'b1; in_data = 16'd22;
    @(negedge clk);
    in_valid = 1'b0;
    expect_out("R10 back-to-back", 1, 4'h0, 7'h00, 16'd42);

    // R9 / R8: consumer stall, then two tokens on consecutive cycles
    out_ready = 1'b0;
    send(4'h8, 7'h20, 1'b0, 16'd1);
    send(4'h8, 7'h20, 1'b1, 16'd2);
    for (int k = 0; k < 3; k++) begin
      check("R9 held token", {out_valid, out_ip, out_port, out_data},
                             {1'b1, 7'h21, 1'b0, 16'd3});
      check("R9 input stalled", 64'(in_ready), 64'(0));
      @(negedge clk);
    end
    out_ready = 1'b1;
    #1;
    check("R8 stall while two pending", 64'(in_ready), 64'(0));
    @(negedge clk);
    check("R8 second token", {out_valid, out_fp, out_ip, out_port, out_data},
                             {1'b1, 4'h8, 7'h22, 1'b1, 16'd3});
    check("R8 ready on last", 64'(in_ready), 64'(1));
    @(negedge clk);
    check("R8 done", 64'(out_valid), 64'(0));

    // R1: reset in mid-run drops a parked operand
    send(4'h9, 7'h00, 1'b0, 16'd50);
    expect_out("R3 park before reset", 0, 4'h9, 7'h00, 16'd0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 mid reset out_valid", 64'(out_valid), 64'(0));
    send(4'h9, 7'h00, 1'b1, 16'd60);
    expect_out("R1 slot cleared by reset", 0, 4'h9, 7'h00, 16'd0);
    send(4'h9, 7'h00, 1'b0, 16'd1);
    expect_out("R4 fire after reset", 1, 4'h9, 7'h00, 16'd61);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule